// File: doc/BRIEF.md
# Bidirectional Funnel Shifter with Rotate

This block is a purely combinational N-bit shifter. It performs logical, arithmetic and rotating shifts, either to the right or to the left, by an amount from 0 to N-1. Every operation uses the same right-selecting funnel. A staging word of 2N-1 bits is filled from the source operand according to the direction and the shift kind. The result is the N-bit window of that word that starts at a computed offset.

A right shift uses the shift amount itself as the offset. A left shift places the operand one position higher in the staging word and uses the bitwise inverse of the amount as the offset. This gives a left shift without computing N minus the amount, so no subtractor sits ahead of the select. The window is picked by a chain of log2(N) rank stages of 2:1 multiplexers, not by one wide multiplexer per output bit.

The block has no clock and no state, and it does not move data as a stream, so there is no handshake and no back-pressure. The result follows the inputs after the combinational delay of the funnel. It is meant to sit inside a datapath stage whose own registers capture the result.

Top module: `funnel_shifter`

## Requirements
- R1: With direction 0 (right) and kind 2'b00 (logical), the result equals the source moved right by the amount, and the vacated top bits are 0.
- R2: With direction 0 and kind 2'b01 (arithmetic), the vacated top bits are copies of the source MSB. Shifting 0x8000_0000 right by N-1 gives all ones, where the logical shift gives 1.
- R3: With direction 0 and kind 2'b10 (rotate), bits that leave the bottom re-enter at the top, so no bit is lost.
- R4: With direction 1 (left) and kind 2'b00 or 2'b01, the result equals the source moved left by the amount, with 0 in the vacated low bits. The two kinds give identical results.
- R5: With direction 1 and kind 2'b10, bits that leave the top re-enter at the bottom.
- R6: An amount of 0 returns the source unchanged for every direction and kind.
- R7: Kind code 2'b11 is reserved and behaves exactly as logical (2'b00) in both directions.
- R8: At N=4 with source 4'b1011 and amount 1, the results are: logical right 0101, arithmetic right 1101, left (logical or arithmetic) 0110, rotate right 1101, rotate left 0111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | N | Operand to be shifted |
| amt_i | input | log2(N) | Shift amount, 0 to N-1 |
| dir_left_i | input | 1 | 0 shifts right, 1 shifts left |
| kind_i | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 reserved (logical) |
| res_o | output | N | Shifted or rotated result |

## Verification
Every amount is swept for all six direction and kind pairs against behavioural shift expressions. The sources are random words, which exercise the fill bits and the window offset together. A walking single one is also used: a misrouted mux rank in the log chain shows up as that bit landing in the wrong position or being dropped, while a wrong fill shows up as stray ones. Negative sources separate sign fill from zero fill. The all-zero amount checks that the inverted left offset still lands on the unshifted window. A separate 4-bit instance reproduces the small worked results, and the reserved code is compared against the logical kind.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    SHK_LOGIC  = 2'b00,
    SHK_ARITH  = 2'b01,
    SHK_ROTATE = 2'b10,
    SHK_RSVD   = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/shf_word_build.sv
// Builds the 2N-1 bit staging word that the right-selecting funnel reads.
module shf_word_build
  import shf_pkg::*;
#(
  parameter int N = 32,
  localparam int ZW = 2 * N - 1
) (
  input  logic [N-1:0]  src,
  input  logic          left,
  input  shift_kind_e   kind,
  output logic [ZW-1:0] zword
);
  logic [N-2:0] upper_fill;
  logic [N-2:0] lower_fill;

  // Right shifts: operand in the low N bits, fill above it.
  always_comb begin
    unique case (kind)
      SHK_ARITH:  upper_fill = {(N-1){src[N-1]}};
      SHK_ROTATE: upper_fill = src[N-2:0];
      default:    upper_fill = '0;
    endcase
  end

  // Left shifts: operand in the high N bits, fill below it.
  always_comb begin
    if (kind == SHK_ROTATE) lower_fill = src[N-1:1];
    else                    lower_fill = '0;
  end

  always_comb begin
    if (left) zword = {src, lower_fill};
    else      zword = {upper_fill, src};
  end
endmodule

// File: rtl/shf_offset.sv
// Window offset: the amount for right shifts, its inverse for left shifts.
module shf_offset #(
  parameter int N = 32,
  localparam int KW = $clog2(N)
) (
  input  logic [KW-1:0] amt,
  input  logic          left,
  output logic [KW-1:0] offset
);
  always_comb offset = left ? ~amt : amt;
endmodule

// File: rtl/shf_log_select.sv
// Picks zword[offset+N-1 : offset] through KW ranks of 2:1 multiplexers.
module shf_log_select #(
  parameter int N = 32,
  localparam int KW = $clog2(N),
  localparam int ZW = 2 * N - 1
) (
  input  logic [ZW-1:0] zword,
  input  logic [KW-1:0] offset,
  output logic [N-1:0]  field
);
  logic [ZW-1:0] rank [0:KW];

  assign rank[0] = zword;

  for (genvar s = 0; s < KW; s++) begin : g_rank
    localparam int STEP = 1 << s;
    always_comb begin
      if (offset[s]) rank[s+1] = {{STEP{1'b0}}, rank[s][ZW-1:STEP]};
      else           rank[s+1] = rank[s];
    end
  end

  assign field = rank[KW][N-1:0];
endmodule

// File: rtl/funnel_shifter.sv
module funnel_shifter
  import shf_pkg::*;
#(
  parameter int N = 32,
  localparam int KW = $clog2(N),
  localparam int ZW = 2 * N - 1
) (
  input  logic [N-1:0]  src_i,
  input  logic [KW-1:0] amt_i,
  input  logic          dir_left_i,
  input  logic [1:0]    kind_i,
  output logic [N-1:0]  res_o
);
  logic [ZW-1:0] zword;
  logic [KW-1:0] offset;
  shift_kind_e   kind;

  assign kind = shift_kind_e'(kind_i);

  shf_word_build #(.N(N)) u_build (
    .src  (src_i),
    .left (dir_left_i),
    .kind (kind),
    .zword(zword)
  );

  shf_offset #(.N(N)) u_offset (
    .amt   (amt_i),
    .left  (dir_left_i),
    .offset(offset)
  );

  shf_log_select #(.N(N)) u_select (
    .zword (zword),
    .offset(offset),
    .field (res_o)
  );
endmodule

// File: rtl/funnel_shifter_chk.sv
module funnel_shifter_chk #(
  parameter int N = 32,
  localparam int KW = $clog2(N)
) (
  input logic [N-1:0]  src_i,
  input logic [KW-1:0] amt_i,
  input logic          dir_left_i,
  input logic [1:0]    kind_i,
  input logic [N-1:0]  res_o
);
  logic [N-1:0] low_mask;
  logic         is_logic;

  always_comb begin
    low_mask = (N'(1) << amt_i) - N'(1);
    is_logic = (kind_i == 2'b00) || (kind_i == 2'b11);

    AST_ZERO_AMOUNT_IDENTITY: assert (amt_i != '0 || res_o == src_i); // R6
    AST_LOGIC_RIGHT_NO_GROWTH: assert (!(is_logic && !dir_left_i) || res_o <= src_i); // R1
    AST_ARITH_SIGN_KEPT: assert (!(kind_i == 2'b01 && !dir_left_i) || res_o[N-1] == src_i[N-1]); // R2
    AST_ROTR_WEIGHT_KEPT: assert (!(kind_i == 2'b10 && !dir_left_i) || $countones(res_o) == $countones(src_i)); // R3
    AST_LEFT_LOW_ZERO: assert (!(kind_i != 2'b10 && dir_left_i) || (res_o & low_mask) == '0); // R4
    AST_ROTL_WEIGHT_KEPT: assert (!(kind_i == 2'b10 && dir_left_i) || $countones(res_o) == $countones(src_i)); // R5
  end
endmodule

bind funnel_shifter funnel_shifter_chk #(.N(N)) u_chk (
  .src_i     (src_i),
  .amt_i     (amt_i),
  .dir_left_i(dir_left_i),
  .kind_i    (kind_i),
  .res_o     (res_o)
);

// File: tb/funnel_shifter_bench.sv
module funnel_shifter_bench;
  localparam int N = 32;
  localparam int KW = $clog2(N);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0]  src;
  logic [KW-1:0] amt;
  logic          left;
  logic [1:0]    kind;
  logic [N-1:0]  res;

  logic [3:0] n_src;
  logic [1:0] n_amt;
  logic       n_left;
  logic [1:0] n_kind;
  logic [3:0] n_res;

  int checks = 0;
  int fails  = 0;

  funnel_shifter #(.N(N)) u_funnel_shifter (
    .src_i(src), .amt_i(amt), .dir_left_i(left), .kind_i(kind), .res_o(res)
  );

  funnel_shifter #(.N(4)) u_funnel_shifter_n4 (
    .src_i(n_src), .amt_i(n_amt), .dir_left_i(n_left), .kind_i(n_kind), .res_o(n_res)
  );

  function automatic logic [N-1:0] ref_shift(logic [N-1:0] a, int k, logic lf, logic [1:0] kd);
    if (kd == 2'b10) begin
      if (lf) return (a << k) | (a >> (N - k));
      else    return (a >> k) | (a << (N - k));
    end else if (kd == 2'b01 && !lf) begin
      return N'($signed(a) >>> k);
    end else begin
      return lf ? (a << k) : (a >> k);
    end
  endfunction

  function automatic string op_tag(logic lf, logic [1:0] kd);
    if (kd == 2'b10) return lf ? "R5" : "R3";
    if (lf)          return "R4";
    if (kd == 2'b01) return "R2";
    if (kd == 2'b11) return "R7";
    return "R1";
  endfunction

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (src %h amt %0d left %0b kind %0b)",
               tag, act, exp, src, amt, left, kind);
    end
  endtask

  task automatic apply(logic [N-1:0] a, int k, logic lf, logic [1:0] kd);
    @(negedge clk);
    src = a; amt = KW'(k); left = lf; kind = kd;
    #1;
  endtask

  task automatic t_idle_state;
    apply('0, 0, 1'b0, 2'b00);
    check("R6 idle", res, '0);
  endtask

  task automatic t_zero_amount;
    for (int lf = 0; lf < 2; lf++)
      for (int kd = 0; kd < 4; kd++) begin
        apply(32'hC3A5_0F96, 0, 1'(lf), 2'(kd));
        check("R6 zero amount", res, 32'hC3A5_0F96);
      end
  endtask

  task automatic t_random_sweep;
    for (int v = 0; v < 6; v++) begin
      logic [N-1:0] a;
      a = $urandom();
      if (v == 0) a[N-1] = 1'b1;
      if (v == 1) a[N-1] = 1'b0;
      for (int lf = 0; lf < 2; lf++)
        for (int kd = 0; kd < 4; kd++)
          for (int k = 0; k < N; k++) begin
            apply(a, k, 1'(lf), 2'(kd));
            check(op_tag(1'(lf), 2'(kd)), res, ref_shift(a, k, 1'(lf), 2'(kd)));
          end
    end
  endtask

  task automatic t_walking_one;
    for (int b = 0; b < N; b++)
      for (int lf = 0; lf < 2; lf++)
        for (int kd = 0; kd < 3; kd++)
          for (int k = 0; k < N; k++) begin
            apply(N'(1) << b, k, 1'(lf), 2'(kd));
            check(op_tag(1'(lf), 2'(kd)), res, ref_shift(N'(1) << b, k, 1'(lf), 2'(kd)));
          end
  endtask

  task automatic t_sign_fill;
    apply(32'h8000_0000, N - 1, 1'b0, 2'b01);
    check("R2 sign fill", res, 32'hFFFF_FFFF);
    apply(32'h8000_0000, N - 1, 1'b0, 2'b00);
    check("R1 zero fill", res, 32'h0000_0001);
    apply(32'h7FFF_FFFF, N - 1, 1'b0, 2'b01);
    check("R2 positive fill", res, 32'h0000_0000);
  endtask

  task automatic t_reserved_kind;
    for (int lf = 0; lf < 2; lf++)
      for (int k = 0; k < N; k += 3) begin
        apply(32'hF00D_8421, k, 1'(lf), 2'b11);
        check("R7 reserved as logical", res, ref_shift(32'hF00D_8421, k, 1'(lf), 2'b00));
      end
  endtask

  task automatic check4(string tag, logic lf, logic [1:0] kd, logic [3:0] exp);
    @(negedge clk);
    n_src = 4'b1011; n_amt = 2'd1; n_left = lf; n_kind = kd;
    #1;
    checks++;
    if (n_res !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, n_res, exp);
    end
  endtask

  task automatic t_narrow_examples;
    check4("R8 logical right",    1'b0, 2'b00, 4'b0101);
    check4("R8 arithmetic right", 1'b0, 2'b01, 4'b1101);
    check4("R8 logical left",     1'b1, 2'b00, 4'b0110);
    check4("R8 arithmetic left",  1'b1, 2'b01, 4'b0110);
    check4("R8 rotate right",     1'b0, 2'b10, 4'b1101);
    check4("R8 rotate left",      1'b1, 2'b10, 4'b0111);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    src = '0; amt = '0; left = 1'b0; kind = 2'b00;
    n_src = '0; n_amt = '0; n_left = 1'b0; n_kind = 2'b00;
    repeat (2) @(posedge clk);
    t_idle_state();
    t_zero_amount();
    t_sign_fill();
    t_reserved_kind();
    t_narrow_examples();
    t_random_sweep();
    t_walking_one();
    report();
    $finish;
  end
endmodule